// File: doc/BRIEF.md
# Phase Offset Virtual Reference Corrector

This block sits between reference selection and the phase detector of a digital timing loop. It picks one of two reference edge strobes and passes it on as a virtual reference. When a reference is switched, or the loop comes back from holdover, a measure command makes the block capture how many master-clock ticks separate the next selected reference edge from the next feedback edge. After that it re-times every selected reference edge by the captured amount. The phase detector then sees a reference that lines up with the feedback, so no phase step reaches the loop.

A clear command drops the captured offset. The virtual reference then follows the raw reference, so the loop pulls its output back into alignment with the input. If no feedback edge arrives within one reference period, the offset falls back to zero and a sticky error flag is raised.

Top module: `vref_phase_corrector`

## Requirements
- R1: `ref_sel` = 0 routes `ref0_edge` and `ref_sel` = 1 routes `ref1_edge`. Edges on the input that is not selected have no effect on any output.
- R2: After a measure command, the measurement starts on the first selected edge in a later cycle. The stored offset becomes the number of cycles from that edge to the first `fb_edge` (0 when both come in the same cycle). Further reference edges during the measurement do not restart it. Feedback edges outside a measurement have no effect.
- R3: `meas_ack` is high for exactly one cycle, in the cycle after the feedback edge that ends a measurement. The new offset applies to selected edges from that cycle onward.
- R4: With stored offset D, a selected edge in cycle t gives a one-cycle `vref_strobe` in cycle t+1+D.
- R5: If cycle P−1 of a measurement passes with no feedback edge (P = `ref_period`), the offset becomes 0, `meas_err` goes high in the next cycle and `meas_ack` stays low.
- R6: `meas_err` stays high until a measure or clear command is applied.
- R7: A clear command sets the offset to 0, aborts any measurement and lowers `meas_err` in the next cycle. It wins over a measure command given in the same cycle.
- R8: A measure command during a measurement restarts it, which then waits for a fresh selected edge.
- R9: After reset the offset is 0, no measurement is active, and all outputs are low.
- R10: A selected edge that arrives while a delayed strobe is still pending replaces the pending strobe with a new one timed from itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref0_edge | input | 1 | Rising-edge strobe of reference 0 |
| ref1_edge | input | 1 | Rising-edge strobe of reference 1 |
| ref_sel | input | 1 | Reference select |
| fb_edge | input | 1 | Rising-edge strobe of the loop feedback |
| meas_req | input | 1 | Measure command pulse |
| clr_req | input | 1 | Clear command pulse |
| ref_period | input | CNT_W | Reference period in master-clock ticks |
| vref_strobe | output | 1 | Virtual reference strobe |
| meas_ack | output | 1 | Measurement-complete pulse |
| meas_err | output | 1 | Sticky measurement timeout flag |

## Verification
The hardest situations to reach from the ports are the ones where timing events overlap. One is a feedback edge landing exactly in the last allowed tick (offset P−1). Another is a second selected edge arriving while a long delayed strobe is still counting down. A third is a measure command given while a measurement is in progress. The stimulus places reference and feedback edges at programmable phases of a free-running tick count, with reference 1 offset from reference 0. It adds single extra edges at chosen phases to set up each overlap. A behavioural model predicts all three outputs on every cycle.

// File: rtl/vref_corr_pkg.sv
package vref_corr_pkg;
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_ARMED = 2'd1,
    MS_COUNT = 2'd2
  } meas_state_e;
endpackage

// File: rtl/vref_edge_select.sv
module vref_edge_select (
  input  logic ref0_edge,
  input  logic ref1_edge,
  input  logic ref_sel,
  output logic sel_edge
);
  always_comb begin
    sel_edge = ref_sel ? ref1_edge : ref0_edge;
  end
endmodule

// File: rtl/vref_offset_meter.sv
module vref_offset_meter
  import vref_corr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_edge,
  input  logic             fb_edge,
  input  logic             meas_req,
  input  logic             clr_req,
  input  logic [CNT_W-1:0] ref_period,
  output logic [CNT_W-1:0] delay_o,
  output logic             ack_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  meas_state_e      st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] dly_q, dly_n;
  logic             cnt_ld, dly_ld;
  logic             err_q, err_n;
  logic             ack_q, ack_n;
  logic [CNT_W-1:0] period_m1;
  logic             last_tick;

  assign period_m1 = ref_period - ONE;
  assign last_tick = (cnt_q >= period_m1);

  // next-state logic
  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    cnt_ld = 1'b0;
    dly_n  = dly_q;
    dly_ld = 1'b0;
    err_n  = err_q;
    ack_n  = 1'b0;
    if (clr_req) begin
      dly_n  = ZERO;
      dly_ld = 1'b1;
      err_n  = 1'b0;
      st_n   = MS_IDLE;
    end else if (meas_req) begin
      err_n = 1'b0;
      st_n  = MS_ARMED;
    end else begin
      case (st_q)
        MS_ARMED: begin
          if (sel_edge) begin
            if (fb_edge) begin
              dly_n  = ZERO;
              dly_ld = 1'b1;
              ack_n  = 1'b1;
              st_n   = MS_IDLE;
            end else begin
              cnt_n  = ONE;
              cnt_ld = 1'b1;
              st_n   = MS_COUNT;
            end
          end
        end
        MS_COUNT: begin
          if (fb_edge) begin
            dly_n  = cnt_q;
            dly_ld = 1'b1;
            ack_n  = 1'b1;
            st_n   = MS_IDLE;
          end else if (last_tick) begin
            dly_n  = ZERO;
            dly_ld = 1'b1;
            err_n  = 1'b1;
            st_n   = MS_IDLE;
          end else begin
            cnt_n  = cnt_q + ONE;
            cnt_ld = 1'b1;
          end
        end
        default: begin
          st_n = MS_IDLE;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MS_IDLE;
      cnt_q <= ZERO;
      dly_q <= ZERO;
      err_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      err_q <= err_n;
      ack_q <= ack_n;
      if (cnt_ld) cnt_q <= cnt_n;
      if (dly_ld) dly_q <= dly_n;
    end
  end

  assign delay_o = dly_q;
  assign ack_o   = ack_q;
  assign err_o   = err_q;
endmodule

// File: rtl/vref_delay_line.sv
module vref_delay_line #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_edge,
  input  logic [CNT_W-1:0] delay_i,
  output logic             strobe_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] dcnt_q, dcnt_n;
  logic             dcnt_ld;
  logic             act_q, act_n;
  logic             stb_q, stb_n;

  // next-state logic
  always_comb begin
    dcnt_n  = dcnt_q;
    dcnt_ld = 1'b0;
    act_n   = act_q;
    stb_n   = 1'b0;
    if (sel_edge) begin
      if (delay_i == ZERO) begin
        stb_n = 1'b1;
        act_n = 1'b0;
      end else begin
        dcnt_n  = delay_i;
        dcnt_ld = 1'b1;
        act_n   = 1'b1;
      end
    end else if (act_q) begin
      if (dcnt_q == ONE) begin
        stb_n = 1'b1;
        act_n = 1'b0;
      end else begin
        dcnt_n  = dcnt_q - ONE;
        dcnt_ld = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= ZERO;
      act_q  <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      act_q <= act_n;
      stb_q <= stb_n;
      if (dcnt_ld) dcnt_q <= dcnt_n;
    end
  end

  assign strobe_o = stb_q;
endmodule

// File: rtl/vref_phase_corrector.sv
module vref_phase_corrector #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref0_edge,
  input  logic             ref1_edge,
  input  logic             ref_sel,
  input  logic             fb_edge,
  input  logic             meas_req,
  input  logic             clr_req,
  input  logic [CNT_W-1:0] ref_period,
  output logic             vref_strobe,
  output logic             meas_ack,
  output logic             meas_err
);
  logic             sel_edge;
  logic [CNT_W-1:0] stored_delay;

  vref_edge_select u_sel (
    .ref0_edge (ref0_edge),
    .ref1_edge (ref1_edge),
    .ref_sel   (ref_sel),
    .sel_edge  (sel_edge)
  );

  vref_offset_meter #(.CNT_W(CNT_W)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_edge   (sel_edge),
    .fb_edge    (fb_edge),
    .meas_req   (meas_req),
    .clr_req    (clr_req),
    .ref_period (ref_period),
    .delay_o    (stored_delay),
    .ack_o      (meas_ack),
    .err_o      (meas_err)
  );

  vref_delay_line #(.CNT_W(CNT_W)) u_dline (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_edge (sel_edge),
    .delay_i  (stored_delay),
    .strobe_o (vref_strobe)
  );
endmodule

// File: rtl/vref_phase_corrector_chk.sv
module vref_phase_corrector_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_edge,
  input logic [CNT_W-1:0] stored_delay,
  input logic             meas_req,
  input logic             clr_req,
  input logic             meas_ack,
  input logic             meas_err,
  input logic             vref_strobe
);
  // R3
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_ack |=> !meas_ack);

  // R4
  zero_offset_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_edge && stored_delay == '0) |=> vref_strobe);

  // R5
  ack_err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_ack && meas_err));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_err && !meas_req && !clr_req) |=> meas_err);

  // R7
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (stored_delay == '0 && !meas_err && !meas_ack));
endmodule

bind vref_phase_corrector vref_phase_corrector_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_edge     (sel_edge),
  .stored_delay (stored_delay),
  .meas_req     (meas_req),
  .clr_req      (clr_req),
  .meas_ack     (meas_ack),
  .meas_err     (meas_err),
  .vref_strobe  (vref_strobe)
);

// File: tb/sim_vref_phase_corrector.sv
`timescale 1ns/1ps
module sim_vref_phase_corrector;
  localparam int CNT_W = 16;
  localparam int P     = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ref0, ref1, ref_sel, fb, meas, clr;
  logic [CNT_W-1:0] period;
  logic vref, ack, err;

  vref_phase_corrector #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ref0_edge(ref0), .ref1_edge(ref1),
    .ref_sel(ref_sel), .fb_edge(fb), .meas_req(meas), .clr_req(clr),
    .ref_period(period), .vref_strobe(vref), .meas_ack(ack), .meas_err(err)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string tag = "R9";

  // stimulus knobs
  int tc = 0;
  int ph0 = 0, ph1 = 6, fbph = 7;
  bit x0 = 0, x1 = 0, xfb = 0, go_meas = 0, go_clr = 0;

  // behavioural model: 0 idle, 1 waiting for edge, 2 counting
  int m_st, m_cnt, m_dly, m_due, m_n;
  bit e_vref, e_ack, e_err, m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_dly = 0; m_due = -1; m_n = 0;
      e_vref = 0; e_ack = 0; e_err = 0;
    end else begin
      m_n++;
      m_sel = ref_sel ? ref1 : ref0;
      if (m_sel) m_due = m_n + m_dly;
      e_vref = (m_due == m_n);
      if (e_vref) m_due = -1;
      e_ack = 0;
      if (clr) begin
        m_dly = 0; e_err = 0; m_st = 0;
      end else if (meas) begin
        e_err = 0; m_st = 1;
      end else if (m_st == 1) begin
        if (m_sel) begin
          if (fb) begin m_dly = 0; e_ack = 1; m_st = 0; end
          else begin m_cnt = 1; m_st = 2; end
        end
      end else if (m_st == 2) begin
        if (fb) begin m_dly = m_cnt; e_ack = 1; m_st = 0; end
        else if (m_cnt >= P - 1) begin m_dly = 0; e_err = 1; m_st = 0; end
        else m_cnt++;
      end
    end
  end

  task automatic check(string req, logic act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, tc, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(tag, vref, e_vref);
    check("R3", ack, e_ack);
    check("R5", err, e_err);
    tc++;
    ref0 = ((tc % P) == ph0) || x0;
    ref1 = ((tc % P) == ph1) || x1;
    fb   = (fbph >= 0 && (tc % P) == fbph) || xfb;
    meas = go_meas;
    clr  = go_clr;
    x0 = 0; x1 = 0; xfb = 0; go_meas = 0; go_clr = 0;
  endtask

  task automatic run(int k);
    repeat (k) tick();
  endtask

  task automatic wait_phase(int ph);
    while ((tc % P) != ph) tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    ref0 = 0; ref1 = 0; ref_sel = 0; fb = 0; meas = 0; clr = 0;
    period = CNT_W'(P);
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", vref, 1'b0);
    check("R9", ack, 1'b0);
    check("R9", err, 1'b0);
    rst_n = 1'b1;
    run(2);
    // R4: zero offset, vref follows ref0 one cycle later; R2 fb ignored
    tag = "R4"; run(50);
    // R2: measure offset 7 on reference 0
    tag = "R2"; go_meas = 1; run(70);
    // R1: switch to reference 1 (phase 6), fb at 7 gives offset 1
    tag = "R1"; ref_sel = 1; go_meas = 1; run(70);
    // R10: offset 15, then an extra edge while a strobe is pending
    tag = "R10"; fbph = 1; go_meas = 1; run(70);
    wait_phase(10); x1 = 1; run(50);
    // R7: clear and measure together, clear wins
    tag = "R7"; go_meas = 1; go_clr = 1; run(50);
    // R5: no feedback, timeout
    tag = "R5"; fbph = -1; go_meas = 1; run(60);
    // R6: error held with no command
    tag = "R6"; run(40);
    // R8: restart a measurement in progress, with an extra ref edge mid count
    tag = "R8"; fbph = 16; go_meas = 1; run(1);
    wait_phase(8); go_meas = 1; run(1);
    wait_phase(9); x1 = 1; run(70);
    // R3: boundary, offset P-1
    tag = "R3"; fbph = 5; go_meas = 1; run(80);
    // R2: feedback in the same cycle as the reference edge
    tag = "R2"; fbph = 6; go_meas = 1; run(60);
    finish_run();
  end
endmodule